// File: doc/BRIEF.md
# Double-Buffered Clock Register Bus Interface

This block sits between a bytewide memory-style bus and a free-running time counter chain. A 13-bit address space is split in two. The eight highest addresses form a window of clock registers, and every lower address reaches a byte RAM. Bus signals arrive as synchronous levels: an active-low select, an active-high select, an active-low output enable and an active-low write enable. They are sampled on each rising edge of the block clock. Read data appears one cycle after the read cycle, together with a drive-enable flag.

The clock registers are a user-visible copy of the counter chain. The chain presents all of its fields on a 64-bit snapshot bus. While neither halt bit is set, the copy follows the snapshot every cycle. A read halt freezes the copy so software can read a coherent time. A write halt also freezes the copy and lets software edit it. Clearing the write halt pushes the whole copy back to the chain as one single-cycle load.

Several control bits share the register window with the time fields:
- an oscillator stop bit;
- a frequency test bit, which lets a test tick drive the seconds LSB on reads;
- a read-only battery flag.

Top module: `rtc_bus_if`

## Requirements
- R1: A read cycle is one where `ce_ni`=0, `ce2_i`=1, `oe_ni`=0 and `we_ni`=1. The cycle after a read cycle has `rdata_oe_o`=1 and carries the addressed byte. In every other cycle `rdata_oe_o`=0 and `rdata_o`=0.
- R2: A byte written to any address below 0x1FF8 reads back unchanged from that address.
- R3: Register k sits at 0x1FF8+k, and its time field is snapshot byte k (`snap_i[8k+7:8k]`) under a mask. The masks for k=0..7 are 3F,7F,7F,3F,07,3F,1F,FF. While both halt bits are 0, the register follows the snapshot with one cycle of delay. All bits outside the masks and the control bits are ignored.
- R4: Register 0 holds the write halt in bit 7, the read halt in bit 6 and the century in bits 5:0. Setting the read halt freezes every time field at the value it had in the write cycle, even while the snapshot changes. Clearing the read halt resumes following one cycle later.
- R5: While the write halt is 1, a write to any register updates its masked time field, and the written value reads back. While the write halt is 0, writes to time fields have no effect. A write to register 0 accepts the century field only when the write halt was already 1.
- R6: A write to register 0 with bit 7 = 0 while the write halt is 1 raises `ld_o` for exactly the following cycle. During that cycle `ld_data_o` byte k carries time field k, including the century from that same write. The copy does not follow the snapshot during that cycle.
- R7: Bit 7 of register 1 is the oscillator stop bit. It is writable at any time, reads back, and drives `osc_stop_o`.
- R8: Bit 6 of register 4 is the frequency test bit. It is writable at any time. When it is 1 and the stop bit is 0, bit 0 of a register 1 read returns `ft_tick_i`. Otherwise bit 0 returns the stored seconds bit.
- R9: Bit 7 of register 4 reads as `batt_ok_i` and ignores writes. Bits 5:3 of register 4, bit 7 of registers 2, 5, 6 and bit 6 of registers 3, 5, 6 always read 0.
- R10: After reset, `rdata_oe_o`, `rdata_o`, `ld_o` and `osc_stop_o` are 0, and all halt, stop and test bits are 0.
- R11: A cycle with `we_ni`=0 but `ce_ni`=1 or `ce2_i`=0 changes neither the RAM nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Select, active low |
| ce2_i | input | 1 | Select, active high |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the read cycle |
| rdata_oe_o | output | 1 | Read data drive enable |
| snap_i | input | 64 | Counter chain fields, byte k for register k |
| ld_o | output | 1 | One-cycle load strobe to the counter chain |
| ld_data_o | output | 64 | Time fields to load, byte k for register k |
| osc_stop_o | output | 1 | Oscillator stop request |
| ft_tick_i | input | 1 | Frequency test tick |
| batt_ok_i | input | 1 | Battery good indication |

## Verification
The hardest state to reach is a transfer whose edits mix with earlier halts. One example is clearing the write halt while the read halt is set in the same byte. Another is writing the century in the same byte that clears the write halt. Each of these must pulse the load exactly once, and the copy must not take a snapshot in the load cycle. The bench acts as the counter chain: it feeds each load back as the next snapshot. Random register writes with random data then toggle both halts in arbitrary orders between snapshot changes. A bench model tracks the expected copy through all of these sequences.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int unsigned NREG = 8;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_SEC   = 3'd1,
    REG_MIN   = 3'd2,
    REG_HOUR  = 3'd3,
    REG_DAY   = 3'd4,
    REG_DATE  = 3'd5,
    REG_MONTH = 3'd6,
    REG_YEAR  = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    logic     clk_hit;
    reg_idx_e idx;
  } bus_acc_t;

  // writable time-field bits per register
  function automatic logic [7:0] field_mask(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h3F;
      3'd1:    return 8'h7F;
      3'd2:    return 8'h7F;
      3'd3:    return 8'h3F;
      3'd4:    return 8'h07;
      3'd5:    return 8'h3F;
      3'd6:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_bus_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          ce_ni,
  input  logic          ce2_i,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output bus_acc_t      acc_o
);
  logic sel;

  assign sel           = !ce_ni && ce2_i;
  assign acc_o.rd      = sel && !oe_ni && we_ni;
  assign acc_o.wr      = sel && !we_ni;
  assign acc_o.clk_hit = &addr_i[AW-1:3];
  assign acc_o.idx     = reg_idx_e'(addr_i[2:0]);
endmodule

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
  parameter int unsigned AW    = 13,
  parameter int unsigned DEPTH = (1 << AW) - 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(addr_i) < DEPTH)) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            rdata_q <= '0;
    else if (re_i && (32'(addr_i) < DEPTH)) rdata_q <= mem[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rtc_clock_regs.sv
module rtc_clock_regs
  import rtc_bus_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  reg_idx_e             idx_i,
  input  logic [7:0]           wdata_i,
  input  logic [8*NREG-1:0]    snap_i,
  input  logic                 ft_tick_i,
  input  logic                 batt_ok_i,
  output logic [7:0]           rdata_o,
  output logic                 ld_o,
  output logic [8*NREG-1:0]    ld_data_o,
  output logic                 osc_stop_o
);
  logic       w_q, r_q, osc_q, ft_q, ld_q;
  logic       refresh;
  logic [7:0] tm [NREG];
  logic [7:0] rd_byte, rdata_q;

  // copy tracks counters only when no halt and no load in flight
  assign refresh = !w_q && !r_q && !ld_q;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [7:0] MSK = field_mask(3'(k));
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (refresh)                            q <= snap_i[8*k +: 8] & MSK;
      else if (wr_i && w_q && idx_i == 3'(k))      q <= wdata_i & MSK;
    end
    assign tm[k] = q;
    assign ld_data_o[8*k +: 8] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= 1'b0;
      r_q   <= 1'b0;
      osc_q <= 1'b0;
      ft_q  <= 1'b0;
      ld_q  <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      if (wr_i) begin
        case (idx_i)
          REG_CTRL: begin
            w_q  <= wdata_i[7];
            r_q  <= wdata_i[6];
            ld_q <= w_q && !wdata_i[7];
          end
          REG_SEC: osc_q <= wdata_i[7];
          REG_DAY: ft_q  <= wdata_i[6];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx_i)
      REG_CTRL: rd_byte = {w_q, r_q, tm[0][5:0]};
      REG_SEC:  rd_byte = {osc_q, tm[1][6:1],
                           (ft_q && !osc_q) ? ft_tick_i : tm[1][0]};
      REG_DAY:  rd_byte = {batt_ok_i, ft_q, 3'b000, tm[4][2:0]};
      default:  rd_byte = tm[idx_i];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_byte;
  end

  assign rdata_o    = rdata_q;
  assign ld_o       = ld_q;
  assign osc_stop_o = osc_q;
endmodule

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_bus_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          ce2_i,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          rdata_oe_o,
  input  logic [63:0]   snap_i,
  output logic          ld_o,
  output logic [63:0]   ld_data_o,
  output logic          osc_stop_o,
  input  logic          ft_tick_i,
  input  logic          batt_ok_i
);
  localparam int unsigned RAM_DEPTH = (1 << AW) - NREG;

  bus_acc_t   acc;
  logic [7:0] reg_rdata, ram_rdata;
  logic       oe_q, sel_clk_q;

  rtc_bus_decode #(.AW(AW)) u_dec (
    .ce_ni  (ce_ni),
    .ce2_i  (ce2_i),
    .oe_ni  (oe_ni),
    .we_ni  (we_ni),
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  rtc_clock_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (acc.wr && acc.clk_hit),
    .rd_i       (acc.rd && acc.clk_hit),
    .idx_i      (acc.idx),
    .wdata_i    (wdata_i),
    .snap_i     (snap_i),
    .ft_tick_i  (ft_tick_i),
    .batt_ok_i  (batt_ok_i),
    .rdata_o    (reg_rdata),
    .ld_o       (ld_o),
    .ld_data_o  (ld_data_o),
    .osc_stop_o (osc_stop_o)
  );

  rtc_byte_ram #(.AW(AW), .DEPTH(RAM_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (acc.wr && !acc.clk_hit),
    .re_i    (acc.rd && !acc.clk_hit),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q      <= 1'b0;
      sel_clk_q <= 1'b0;
    end else begin
      oe_q <= acc.rd;
      if (acc.rd) sel_clk_q <= acc.clk_hit;
    end
  end

  assign rdata_oe_o = oe_q;
  assign rdata_o    = !oe_q ? 8'h00 : (sel_clk_q ? reg_rdata : ram_rdata);
endmodule

// File: rtl/rtc_bus_if_chk.sv
module rtc_bus_if_chk #(
  parameter int unsigned AW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          ce2_i,
  input logic          oe_ni,
  input logic          we_ni,
  input logic [AW-1:0] addr_i,
  input logic [7:0]    wdata_i,
  input logic [7:0]    rdata_o,
  input logic          rdata_oe_o,
  input logic [63:0]   snap_i,
  input logic          ld_o,
  input logic [63:0]   ld_data_o,
  input logic          osc_stop_o,
  input logic          ft_tick_i,
  input logic          batt_ok_i
);
  localparam logic [AW-1:0] CTRL_A = {{(AW-3){1'b1}}, 3'd0};
  localparam logic [AW-1:0] SEC_A  = {{(AW-3){1'b1}}, 3'd1};

  logic rd_acc, wr_acc;
  assign rd_acc = !ce_ni && ce2_i && !oe_ni && we_ni;
  assign wr_acc = !ce_ni && ce2_i && !we_ni;

  // R1
  read_oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_acc |=> rdata_oe_o);
  // R1
  read_oe_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> !rdata_oe_o);
  // R1
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> rdata_o == 8'h00);
  // R6
  load_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> !ld_o);
  // R6
  load_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |-> $past(wr_acc && addr_i == CTRL_A && !wdata_i[7]));
  // R7
  osc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_acc && addr_i == SEC_A) |=> $stable(osc_stop_o));
  // R11
  deselect_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || !ce2_i) |=> !ld_o);
endmodule

bind rtc_bus_if rtc_bus_if_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_rtc_bus_if.sv
module tb_rtc_bus_if;
  localparam int CLK_P = 10;
  localparam logic [12:0] CBASE = 13'h1FF8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_n, ce2, oe_n, we_n;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata_o;
  logic        rdata_oe_o;
  logic [63:0] snap;
  logic        ld_o;
  logic [63:0] ld_data_o;
  logic        osc_stop_o;
  logic        tick, batt;

  int n_run = 0, n_fail = 0;

  // bench model
  logic [7:0] um [8];
  logic       mw = 0, mr = 0, mosc = 0, mft = 0;
  logic [7:0] bmem [16];

  always #(CLK_P/2) clk = ~clk;

  rtc_bus_if dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .ce2_i(ce2), .oe_ni(oe_n),
    .we_ni(we_n), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o),
    .rdata_oe_o(rdata_oe_o), .snap_i(snap), .ld_o(ld_o), .ld_data_o(ld_data_o),
    .osc_stop_o(osc_stop_o), .ft_tick_i(tick), .batt_ok_i(batt)
  );

  function automatic logic [7:0] msk(input int k);
    logic [7:0] t [8] = '{8'h3F, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    return t[k];
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    case (k)
      0: return {mw, mr, um[0][5:0]};
      1: return {mosc, um[1][6:1], (mft && !mosc) ? tick : um[1][0]};
      4: return {batt, mft, 3'b000, um[4][2:0]};
      default: return um[k];
    endcase
  endfunction

  function automatic logic [63:0] pack_um();
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = um[k];
    return v;
  endfunction

  function automatic logic [12:0] pool_addr(input int i);
    return (i < 8) ? 13'(i) : 13'(13'h1FF0 + i - 8);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic idle();
    ce_n = 1; ce2 = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic model_refresh();
    if (!mw && !mr)
      for (int k = 0; k < 8; k++) um[k] = snap[8*k +: 8] & msk(k);
  endtask

  task automatic set_snap(input logic [63:0] v);
    snap = v;
    model_refresh();
  endtask

  task automatic bus_wr(input logic [12:0] a, input logic [7:0] d);
    ce_n = 0; ce2 = 1; oe_n = 1; we_n = 0; addr = a; wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [7:0] d, input string req);
    @(negedge clk);
    ce_n = 0; ce2 = 1; oe_n = 0; we_n = 1; addr = a;
    @(negedge clk);
    d = rdata_o;
    chk(req, rdata_oe_o, 1'b1);
    idle();
  endtask

  task automatic rd_reg(input int k, input string req);
    logic [7:0] d;
    bus_rd(CBASE + 13'(k), d, req);
    chk(req, d, exp_byte(k));
  endtask

  task automatic clk_wr(input int k, input logic [7:0] d);
    logic pw, ldx;
    pw = mw; ldx = 0;
    bus_wr(CBASE + 13'(k), d);
    if (k == 0) begin
      if (pw) um[0] = d & 8'h3F;
      mw = d[7]; mr = d[6];
      ldx = pw && !d[7];
    end else begin
      if (pw) um[k] = d & msk(k);
      if (k == 1) mosc = d[7];
      if (k == 4) mft = d[6];
    end
    chk("R6 ld_o", ld_o, ldx);
    if (ldx) begin
      chk("R6 ld_data", ld_data_o, pack_um());
      snap = pack_um();   // bench acts as counter chain
      @(negedge clk);
      chk("R6 ld single", ld_o, 1'b0);
    end
    chk("R7 osc_stop", osc_stop_o, mosc);
    model_refresh();
  endtask

  task automatic ram_wr(input int i, input logic [7:0] d);
    bus_wr(pool_addr(i), d);
    bmem[i] = d;
  endtask

  task automatic ram_rd(input int i, input string req);
    logic [7:0] d;
    bus_rd(pool_addr(i), d, req);
    chk(req, d, bmem[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240607));
    rst_n = 0; idle(); addr = '0; wdata = '0; snap = '0; tick = 0; batt = 1;
    for (int k = 0; k < 8; k++) um[k] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 oe", rdata_oe_o, 0);
    chk("R10 rdata", rdata_o, 0);
    chk("R10 ld", ld_o, 0);
    chk("R10 osc", osc_stop_o, 0);
    rst_n = 1;
    @(negedge clk);
    rd_reg(0, "R10 ctrl");

    // R3 snapshot following
    for (int j = 0; j < 3; j++) begin
      set_snap({$urandom, $urandom});
      for (int k = 0; k < 8; k++) rd_reg(k, "R3 follow");
    end

    // R1 no read when oe high; oe drops after read
    @(negedge clk);
    ce_n = 0; ce2 = 1; oe_n = 1; we_n = 1; addr = CBASE;
    @(negedge clk);
    chk("R1 no-oe read", {rdata_oe_o, rdata_o}, 9'h0);
    idle();
    @(negedge clk);
    chk("R1 idle", {rdata_oe_o, rdata_o}, 9'h0);

    // R2 RAM incl. top boundary 0x1FF7
    for (int i = 0; i < 16; i++) ram_wr(i, 8'($urandom));
    for (int i = 0; i < 16; i++) ram_rd(i, "R2 ram");

    // R4 read halt
    set_snap(64'h2359_5912_0405_3120);
    clk_wr(0, 8'h40);
    set_snap(64'h9912_3107_2359_5919);
    for (int k = 0; k < 8; k++) rd_reg(k, "R4 frozen");
    clk_wr(0, 8'h00);
    for (int k = 0; k < 8; k++) rd_reg(k, "R4 resume");

    // R5 writes ignored while W=0
    clk_wr(2, 8'h45);
    rd_reg(2, "R5 ignored");

    // R5/R6 write halt, edit, transfer with century in clearing write
    clk_wr(0, 8'h80);
    set_snap(64'h0);
    clk_wr(1, 8'h37); clk_wr(2, 8'h59); clk_wr(3, 8'h23); clk_wr(5, 8'h31);
    clk_wr(6, 8'h12); clk_wr(7, 8'h99); clk_wr(4, 8'h07);
    for (int k = 1; k < 8; k++) rd_reg(k, "R5 edit");
    clk_wr(0, 8'h15);
    chk("R6 century", ld_data_o[7:0], 8'h15);
    for (int k = 0; k < 8; k++) rd_reg(k, "R6 after load");

    // R6 clear W while setting R
    clk_wr(0, 8'h80);
    clk_wr(3, 8'h11);
    clk_wr(0, 8'h40);
    set_snap({$urandom, $urandom});
    rd_reg(3, "R6 load held by R");
    clk_wr(0, 8'h00);

    // R7 oscillator stop
    clk_wr(1, 8'h80);
    rd_reg(1, "R7 osc set");
    clk_wr(1, 8'h00);
    rd_reg(1, "R7 osc clr");

    // R8 frequency test
    clk_wr(4, 8'h40);
    tick = 1; rd_reg(1, "R8 tick1");
    tick = 0; rd_reg(1, "R8 tick0");
    clk_wr(1, 8'h80);
    tick = 1; rd_reg(1, "R8 stopped");
    clk_wr(1, 8'h00); clk_wr(4, 8'h00);
    rd_reg(1, "R8 off");

    // R9 battery flag and unused bits
    batt = 0; rd_reg(4, "R9 batt low");
    batt = 1;
    clk_wr(0, 8'h80);
    for (int k = 1; k < 8; k++) clk_wr(k, (k == 1 || k == 4) ? 8'h3F : 8'hFF);
    for (int k = 1; k < 8; k++) rd_reg(k, "R9 masks");
    batt = 0; rd_reg(4, "R9 batt ro");
    batt = 1;
    clk_wr(0, 8'h00);

    // R11 deselected write
    @(negedge clk);
    ce_n = 0; ce2 = 0; we_n = 0; addr = CBASE; wdata = 8'hC0;
    @(negedge clk);
    ce_n = 1; ce2 = 1; addr = pool_addr(3); wdata = ~bmem[3];
    @(negedge clk);
    idle();
    rd_reg(0, "R11 ctrl");
    ram_rd(3, "R11 ram");

    // random phase
    for (int n = 0; n < 500; n++) begin
      int op;
      op = $urandom % 7;
      case (op)
        0: set_snap({$urandom, $urandom});
        1, 2: clk_wr($urandom % 8, 8'($urandom));
        3: rd_reg($urandom % 8, "R3 random");
        4: ram_wr($urandom % 16, 8'($urandom));
        5: ram_rd($urandom % 16, "R2 random");
        default: begin tick = $urandom % 2; batt = $urandom % 2; end
      endcase
    end

    summary();
    $finish;
  end
endmodule